// File: doc/BRIEF.md
# Memory-mapped GPIO controller with pin interrupts

This block gives software control of up to 31 general-purpose pins through a word-addressed register bus with 32-bit data. Each pin has a direction bit and an output latch. The output latch is never written directly. Software changes it only through a set strobe register and a clear strobe register, so one write can change some pins without a read-modify-write of the others. Every pin input passes through a two-flop synchronizer, and software reads the synchronized levels from an input register.

Each pin also has its own interrupt source. An enable bit gates detection. A type bit selects edge or level detection, and a polarity bit selects which edge or level is active. A pending register shows which sources have fired. A mask register selects which pending bits drive the single interrupt output. Hardware does not detect both edges of a pin. Software gets the same result by reading the pin level and programming the opposite polarity after each event.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pin_oe_o` all zero), `pin_o` is all zero, the interrupt enable, type, polarity and mask registers and all pending bits read zero, and `irq_o` is 0.
- R2: A write to byte address 0x0C drives high every pin whose data bit is 1. A write to 0x10 drives low every pin whose data bit is 1. Data bits that are 0 leave those pins unchanged. The new value is on `pin_o` the cycle after the write. Reads of 0x0C and 0x10 both return the output latch.
- R3: The direction register is at 0x00 and reads back exactly as written. With `DIR_INV`=0, a 1 bit makes that pin an output. With `DIR_INV`=1, a 1 bit makes it an input, so the reset value of the register is all ones.
- R4: Address 0x04 returns the pin levels after a two-flop synchronizer. A level applied before clock edge k can be read after edge k+1.
- R5: A pin with type bit 0 (edge, register 0x18) and enable bit 1 (register 0x14) latches its pending bit (register 0x20) on a rising edge when its polarity bit (register 0x1C) is 1, and on a falling edge when it is 0. The bit stays set after the pin returns to its previous level.
- R6: Writing 1 to a bit at 0x20 clears an edge-latched pending bit. Zero data bits have no effect. Writes to 0x20 do not change a level-type pending bit.
- R7: A pin with type bit 1 (level) and enable bit 1 shows a pending bit equal to 1 exactly while its synchronized level equals its polarity bit. The bit drops when the level goes away, with no write from software.
- R8: While a pin's enable bit is 0, an edge on that pin does not latch a pending bit, and a level-type pin reads as not pending.
- R9: `irq_o` is 1 exactly when some pending bit is 1 and the mask bit at the same position (register 0x24) is also 1.
- R10: Reads of addresses that hold no register (such as 0x08, 0x28, 0x3C) return zero. Register bits at positions `NPIN` and above read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; bits [1:0] are ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pin_i | input | NPIN | Asynchronous pin levels |
| pin_o | output | NPIN | Output latch |
| pin_oe_o | output | NPIN | Per-pin output enable |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench targets these corner cases:

- **Sticky edge bits.** An edge pending bit must survive the pin returning to its previous level. A design that derives edge pending from the current level would lose the event.
- **Selective clears.** A clear of one pending bit must not disturb the others, and a write-one-to-clear must leave level bits alone. A design that cleared the whole register, or cleared level state, would fail here.
- **Disabled pins.** Edges on a disabled pin must not latch, and re-enabling a level-low pin must flag it at once. A design that gates only the output would instead report stale events after re-enable.
- **Inverted direction and latency.** The inverted-direction variant must drive the complement of the direction register. The input register must keep its old value one cycle after a pin change. A design with a missing or extra sync flop shows up here.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BUS_W      = 32;
  // word indices (byte address >> 2)
  localparam int unsigned WORD_DIR   = 0;
  localparam int unsigned WORD_IN    = 1;
  localparam int unsigned WORD_SET   = 3;
  localparam int unsigned WORD_CLR   = 4;
  localparam int unsigned WORD_IEN   = 5;
  localparam int unsigned WORD_ITYP  = 6;
  localparam int unsigned WORD_IPOL  = 7;
  localparam int unsigned WORD_IPEND = 8;
  localparam int unsigned WORD_IMSK  = 9;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned NPIN = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] sync_o,
  output logic [NPIN-1:0] prev_o
);
  logic [NPIN-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign sync_o = s2_q;
  assign prev_o = s3_q;

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (sync_o == $past(pin_i, 2))); // R4
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned NPIN = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] lvl_i,
  input  logic [NPIN-1:0] prev_i,
  input  logic [NPIN-1:0] en_i,
  input  logic [NPIN-1:0] type_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] clr_i,
  output logic [NPIN-1:0] pend_o
);
  logic [NPIN-1:0] latch_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic edge_hit, lvl_hit;
    assign edge_hit = pol_i[i] ? (lvl_i[i] & ~prev_i[i]) : (~lvl_i[i] & prev_i[i]);
    assign lvl_hit  = (lvl_i[i] == pol_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   latch_q[i] <= 1'b0;
      else if (type_i[i])            latch_q[i] <= 1'b0;
      else if (en_i[i] && edge_hit)  latch_q[i] <= 1'b1;
      else if (clr_i[i])             latch_q[i] <= 1'b0;
    end

    assign pend_o[i] = type_i[i] ? (en_i[i] & lvl_hit) : latch_q[i];

    AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (latch_q[i] && !type_i[i] && !clr_i[i]) |=> latch_q[i]); // R5
  end

  AST_LEVEL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o & type_i & ~en_i) == '0)); // R8
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPIN    = 24,
  parameter int unsigned ADDR_W  = 6,
  parameter bit          DIR_INV = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [NPIN-1:0]   pin_i,
  output logic [NPIN-1:0]   pin_o,
  output logic [NPIN-1:0]   pin_oe_o,
  output logic              irq_o
);
  localparam int unsigned WIDX = ADDR_W - 2;
  localparam logic [NPIN-1:0] DIR_RST = DIR_INV ? '1 : '0;

  logic [WIDX-1:0] word;
  logic [NPIN-1:0] wd;
  logic            wr;
  logic            unused_bits;

  assign word = addr_i[ADDR_W-1:2];
  assign wd   = wdata_i[NPIN-1:0];
  assign wr   = req_i & we_i;
  assign unused_bits = ^{addr_i[1:0], wdata_i[BUS_W-1:NPIN]};

  logic [NPIN-1:0] dir_q, out_q, ien_q, ityp_q, ipol_q, imsk_q;
  logic [NPIN-1:0] lvl, prev, pend, clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= DIR_RST;
      out_q  <= '0;
      ien_q  <= '0;
      ityp_q <= '0;
      ipol_q <= '0;
      imsk_q <= '0;
    end else if (wr) begin
      case (word)
        WIDX'(WORD_DIR):  dir_q  <= wd;
        WIDX'(WORD_SET):  out_q  <= out_q | wd;
        WIDX'(WORD_CLR):  out_q  <= out_q & ~wd;
        WIDX'(WORD_IEN):  ien_q  <= wd;
        WIDX'(WORD_ITYP): ityp_q <= wd;
        WIDX'(WORD_IPOL): ipol_q <= wd;
        WIDX'(WORD_IMSK): imsk_q <= wd;
        default: ;
      endcase
    end
  end

  assign clr = (wr && word == WIDX'(WORD_IPEND)) ? wd : '0;

  gpio_sync #(.NPIN(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (lvl),
    .prev_o (prev)
  );

  gpio_irq_unit #(.NPIN(NPIN)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .prev_i (prev),
    .en_i   (ien_q),
    .type_i (ityp_q),
    .pol_i  (ipol_q),
    .clr_i  (clr),
    .pend_o (pend)
  );

  logic [NPIN-1:0] rd;
  always_comb begin
    case (word)
      WIDX'(WORD_DIR):   rd = dir_q;
      WIDX'(WORD_IN):    rd = lvl;
      WIDX'(WORD_SET):   rd = out_q;
      WIDX'(WORD_CLR):   rd = out_q;
      WIDX'(WORD_IEN):   rd = ien_q;
      WIDX'(WORD_ITYP):  rd = ityp_q;
      WIDX'(WORD_IPOL):  rd = ipol_q;
      WIDX'(WORD_IPEND): rd = pend;
      WIDX'(WORD_IMSK):  rd = imsk_q;
      default:           rd = '0;
    endcase
  end

  assign rdata_o  = {{(BUS_W-NPIN){1'b0}}, rd};
  assign pin_o    = out_q;
  assign pin_oe_o = DIR_INV ? ~dir_q : dir_q;
  assign irq_o    = |(pend & imsk_q);

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word == WIDX'(WORD_SET)) |=> ((pin_o & $past(wd)) == $past(wd))); // R2
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && word == WIDX'(WORD_CLR)) |=> ((pin_o & $past(wd)) == '0)); // R2
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (imsk_q != '0)); // R9
endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int unsigned N = 24;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [N-1:0] pins = '0;
  logic [N-1:0] po0, oe0, po1, oe1;
  logic irq0, irq1;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.NPIN(N), .ADDR_W(6), .DIR_INV(1'b0)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata0), .pin_i(pins), .pin_o(po0),
    .pin_oe_o(oe0), .irq_o(irq0));

  gpio_irq_ctrl #(.NPIN(N), .ADDR_W(6), .DIR_INV(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata1), .pin_i(pins), .pin_o(po1),
    .pin_oe_o(oe1), .irq_o(irq1));

  task automatic check(input string req_tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req_tag, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1;
    d = rdata0;
  endtask

  function automatic logic [31:0] ext(input logic [N-1:0] v);
    return {{(32-N){1'b0}}, v};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    logic [N-1:0] exp_out;
    void'($urandom(32'h5eed_0042));
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R1 reset state
    check("R1 oe", ext(oe0), 0);
    check("R1 oe inv", ext(oe1), 0);
    check("R1 out", ext(po0), 0);
    check("R1 irq", {31'd0, irq0}, 0);
    for (int a = 20; a <= 36; a += 4) begin
      rd(6'(a), r); check("R1 intregs", r, 0);
    end
    rd(6'h00, r); check("R1 dir", r, 0);

    // R3 direction sense, both variants
    wr(6'h00, 32'h00F0F0);
    check("R3 oe normal", ext(oe0), 32'h00F0F0);
    check("R3 oe inverted", ext(oe1), ext(~N'(32'h00F0F0)));
    rd(6'h00, r); check("R3 readback", r, 32'h00F0F0);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, r); check("R10 dir upper bits", r, ext(ALL));

    // R2 set/clear, random
    exp_out = '0;
    for (int k = 0; k < 40; k++) begin
      logic [31:0] v;
      v = $urandom;
      if (v[31]) begin
        wr(6'h0C, v); exp_out = exp_out | v[N-1:0];
      end else begin
        wr(6'h10, v); exp_out = exp_out & ~v[N-1:0];
      end
      check("R2 pin_o", ext(po0), ext(exp_out));
    end
    rd(6'h0C, r); check("R2 read set addr", r, ext(exp_out));
    rd(6'h10, r); check("R2 read clr addr", r, ext(exp_out));
    wr(6'h0C, 32'h0); check("R2 zero set no effect", ext(po0), ext(exp_out));
    wr(6'h10, 32'h0); check("R2 zero clr no effect", ext(po0), ext(exp_out));

    // R4 input sync latency
    for (int k = 0; k < 10; k++) begin
      logic [N-1:0] old, nv;
      old = pins; nv = N'($urandom);
      if (nv == old) nv = ~old;
      @(negedge clk); pins = nv;
      wait_cyc(1);
      rd(6'h04, r); check("R4 old after 1 edge", r, ext(old));
      wait_cyc(1);
      rd(6'h04, r); check("R4 new after 2 edges", r, ext(nv));
    end

    // R10 unused addresses
    rd(6'h08, r); check("R10 0x08", r, 0);
    rd(6'h28, r); check("R10 0x28", r, 0);
    rd(6'h3C, r); check("R10 0x3C", r, 0);

    // interrupts: p0 rise edge, p1 fall edge, p2 level high, p3 level low
    @(negedge clk); pins = '0; wait_cyc(4);
    wr(6'h18, 32'hC);
    wr(6'h1C, 32'h5);
    wr(6'h24, 32'h0);
    wr(6'h14, 32'hF);
    wait_cyc(1);
    rd(6'h20, r); check("R7 level low active", r, 32'h8);
    check("R9 masked off", {31'd0, irq0}, 0);

    pins = N'(32'hF); wait_cyc(4);
    rd(6'h20, r); check("R5 R7 rising", r, 32'h5);
    pins = N'(32'h8); wait_cyc(4);
    rd(6'h20, r); check("R5 sticky + falling", r, 32'h3);

    wr(6'h20, 32'h2); rd(6'h20, r); check("R6 clear one", r, 32'h1);
    wr(6'h20, 32'h0); rd(6'h20, r); check("R6 zero write", r, 32'h1);
    wr(6'h20, 32'h1); rd(6'h20, r); check("R6 clear other", r, 32'h0);

    wr(6'h24, 32'h2);
    pins = N'(32'hA); wait_cyc(4);
    pins = N'(32'h8); wait_cyc(4);
    rd(6'h20, r); check("R5 falling again", r, 32'h2);
    check("R9 irq masked on", {31'd0, irq0}, 1);
    wr(6'h24, 32'h1);
    check("R9 irq other mask", {31'd0, irq0}, 0);
    wr(6'h20, 32'h2);

    // R8 enable gating
    wr(6'h14, 32'h0);
    pins = N'(32'hF); wait_cyc(4);
    rd(6'h20, r); check("R8 disabled high", r, 0);
    pins = N'(32'h0); wait_cyc(4);
    rd(6'h20, r); check("R8 disabled low", r, 0);
    wr(6'h14, 32'hF);
    rd(6'h20, r); check("R8 reenable level only", r, 32'h8);

    // R7 level follows input, R6 no clear on level
    wr(6'h24, 32'h8);
    check("R9 level irq", {31'd0, irq0}, 1);
    wr(6'h20, 32'h8);
    rd(6'h20, r); check("R6 level ignores clear", r, 32'h8);
    pins = N'(32'h8); wait_cyc(4);
    rd(6'h20, r); check("R7 level drops", r, 32'h0);
    check("R9 irq drops", {31'd0, irq0}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule